// File: doc/BRIEF.md
# Flash Mode-Control Register Interlock

This block is a small bank of byte-wide registers on an 8-bit peripheral bus that governs how on-chip flash enters its program, program-verify, erase and erase-verify modes. Software writes a mode-control byte. The block accepts each bit only if the bits it depends on were already in place. Write-enable must come first. A setup bit must be held before its action bit. Only one action may be active at any time. Four decoded mode lines leave the block and go to the flash controller.

A global enable register controls access to the other four registers. While it is off, writes to them are dropped and reads from them return zero. The erase-block select register and the power-control register only hold values while write-enable is set. Both are cleared on the same clock edge that clears write-enable. A standby input clears the mode-control register, and therefore everything that depends on it.

Top module: `flash_mode_guard`

## Requirements
- R1: After a synchronous reset, every register reads 0x00 and all four mode outputs and the erase-block and power-control outputs are 0.
- R2: The enable register at 0xFF9B is always accessible. Its bit 7 is the access enable, and its other bits read 0. While bit 7 is 0, writes to 0xFF90, 0xFF91, 0xFF92 and 0xFF93 are ignored and reads from them return 0x00. Unmapped addresses read 0x00.
- R3: The mode-control register at 0xFF90 has this layout: bit 6 write-enable, bit 5 erase setup, bit 4 program setup, bit 3 erase-verify, bit 2 program-verify, bit 1 erase, bit 0 program. Bit 7 always reads 0.
- R4: While the stored write-enable bit is 0, a write to the mode-control register can only change bit 6. Bits 5..0 are stored as 0.
- R5: The program bit is stored as 1 only if program setup is already 1 and the same write also keeps program setup at 1. Otherwise the program bit is stored as 0 and the rest of the write is applied.
- R6: The erase bit is stored as 1 only if erase setup is already 1 and the same write also keeps erase setup at 1. Otherwise the erase bit is stored as 0 and the rest of the write is applied.
- R7: While write-enable is 1, writing a verify bit (bit 3 or bit 2) sets the matching verify mode.
- R8: A write that clears write-enable while it is 1 leaves the whole mode-control register at 0x00 after that edge.
- R9: If, after the rules in R5 and R6 are applied, a write would leave more than one of bits 3..0 set, the write is rejected and the previous value is kept.
- R10: The erase-block register at 0xFF93 stores only bits 4..0, and bits 7..5 read 0. It accepts writes only while write-enable is 1. It is 0 whenever write-enable is 0, and it is cleared on the edge where write-enable clears.
- R11: The power-control register at 0xFF92 stores 8 bits and follows the same write-enable rule as R10.
- R12: A high standby input clears the mode-control register on the next edge, and it takes priority over a write in the same cycle. The erase-block and power-control registers clear on that same edge.
- R13: The outputs mode_prog_o, mode_pvfy_o, mode_erase_o and mode_evfy_o follow bits 0, 2, 1 and 3 of the mode-control register. At most one of them is high at a time.
- R14: The status register at 0xFF91 is read-only and reads 0x00. Writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby request; clears mode control |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| mode_prog_o | output | 1 | Program mode active |
| mode_pvfy_o | output | 1 | Program-verify mode active |
| mode_erase_o | output | 1 | Erase mode active |
| mode_evfy_o | output | 1 | Erase-verify mode active |
| erase_blk_o | output | 5 | Selected erase blocks |
| pwr_ctl_o | output | 8 | Power-control value |

## Verification
Two cases can fall in the same cycle. In the first, standby is asserted together with a bus write to the mode-control register. In the second, a write that clears write-enable meets the dependent erase-block and power-control registers, which must clear on that same edge. The directed part of the bench raises standby during a write that would otherwise enter program mode, and expects mode control, the erase-block value and the mode outputs to be zero one edge later. The random part mixes occasional standby pulses with writes to every address, and compares each edge against a bench model that gives standby priority and clears the dependents together with write-enable.

// File: rtl/fmg_pkg.sv
package fmg_pkg;

    localparam int unsigned BUS_AW = 16;
    localparam int unsigned BUS_DW = 8;

    localparam logic [BUS_AW-1:0] ADDR_MODE = 16'hFF90;
    localparam logic [BUS_AW-1:0] ADDR_STAT = 16'hFF91;
    localparam logic [BUS_AW-1:0] ADDR_PWR  = 16'hFF92;
    localparam logic [BUS_AW-1:0] ADDR_EBLK = 16'hFF93;
    localparam logic [BUS_AW-1:0] ADDR_ENA  = 16'hFF9B;

    localparam int unsigned ENA_BIT = 7;

    // Mode-control byte; field order is the bus-visible bit order.
    typedef struct packed {
        logic rsv;
        logic wen;
        logic esu;
        logic psu;
        logic evfy;
        logic pvfy;
        logic ers;
        logic prg;
    } mode_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_STAT,
        SEL_PWR,
        SEL_EBLK,
        SEL_ENA
    } sel_e;

    function automatic logic [2:0] action_count(mode_t m);
        return 3'(m.prg) + 3'(m.ers) + 3'(m.pvfy) + 3'(m.evfy);
    endfunction

    // Next mode-control value for an accepted bus write.
    function automatic mode_t mode_update(mode_t cur, logic [BUS_DW-1:0] w);
        mode_t req;
        mode_t nxt;
        req = mode_t'(w);
        nxt = '0;
        if (!cur.wen) begin
            nxt.wen = req.wen;
        end else if (req.wen) begin
            nxt     = req;
            nxt.rsv = 1'b0;
            nxt.prg = req.prg & req.psu & cur.psu;
            nxt.ers = req.ers & req.esu & cur.esu;
            if (action_count(nxt) > 3'd1) begin
                nxt = cur;
            end
        end
        return nxt;
    endfunction

endpackage

// File: rtl/fmg_decode.sv
module fmg_decode
    import fmg_pkg::*;
#(
    parameter int unsigned       ADDR_W = BUS_AW,
    parameter logic [ADDR_W-1:0] A_MODE = ADDR_MODE,
    parameter logic [ADDR_W-1:0] A_STAT = ADDR_STAT,
    parameter logic [ADDR_W-1:0] A_PWR  = ADDR_PWR,
    parameter logic [ADDR_W-1:0] A_EBLK = ADDR_EBLK,
    parameter logic [ADDR_W-1:0] A_ENA  = ADDR_ENA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              access_en,
    output sel_e              sel,
    output logic              wr_mode,
    output logic              wr_pwr,
    output logic              wr_eblk,
    output logic              wr_ena
);

    always_comb begin
        unique case (addr)
            A_MODE:  sel = SEL_MODE;
            A_STAT:  sel = SEL_STAT;
            A_PWR:   sel = SEL_PWR;
            A_EBLK:  sel = SEL_EBLK;
            A_ENA:   sel = SEL_ENA;
            default: sel = SEL_NONE;
        endcase
    end

    always_comb begin
        wr_mode = we && access_en && (sel == SEL_MODE);
        wr_pwr  = we && access_en && (sel == SEL_PWR);
        wr_eblk = we && access_en && (sel == SEL_EBLK);
        wr_ena  = we && (sel == SEL_ENA);
    end

endmodule

// File: rtl/fmg_mode_ctl.sv
module fmg_mode_ctl
    import fmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              standby,
    input  logic              wr,
    input  logic [BUS_DW-1:0] wdata,
    output mode_t             mode_q,
    output logic              wen_next
);

    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (standby) begin
            mode_d = '0;
        end else if (wr) begin
            mode_d = mode_update(mode_q, wdata);
        end
    end

    assign wen_next = mode_d.wen;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/fmg_dep_reg.sv
module fmg_dep_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_ok,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    logic [W-1:0] d;

    always_comb begin
        if (!hold_ok) begin
            d = '0;
        end else if (wr) begin
            d = wdata;
        end else begin
            d = q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/flash_mode_guard.sv
module flash_mode_guard
    import fmg_pkg::*;
#(
    parameter int unsigned       ADDR_W = BUS_AW,
    parameter int unsigned       EBLK_W = 5,
    parameter int unsigned       PWR_W  = 8,
    parameter logic [ADDR_W-1:0] A_MODE = ADDR_MODE,
    parameter logic [ADDR_W-1:0] A_STAT = ADDR_STAT,
    parameter logic [ADDR_W-1:0] A_PWR  = ADDR_PWR,
    parameter logic [ADDR_W-1:0] A_EBLK = ADDR_EBLK,
    parameter logic [ADDR_W-1:0] A_ENA  = ADDR_ENA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              standby_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    output logic              mode_prog_o,
    output logic              mode_pvfy_o,
    output logic              mode_erase_o,
    output logic              mode_evfy_o,
    output logic [EBLK_W-1:0] erase_blk_o,
    output logic [PWR_W-1:0]  pwr_ctl_o
);

    localparam int unsigned DATA_W = $bits(mode_t);

    sel_e             sel;
    logic             wr_mode, wr_pwr, wr_eblk, wr_ena;
    logic             ena_q;
    mode_t            mode_q;
    logic             wen_next;
    logic [EBLK_W-1:0] eblk_q;
    logic [PWR_W-1:0]  pwr_q;

    fmg_decode #(
        .ADDR_W (ADDR_W),
        .A_MODE (A_MODE),
        .A_STAT (A_STAT),
        .A_PWR  (A_PWR),
        .A_EBLK (A_EBLK),
        .A_ENA  (A_ENA)
    ) u_decode (
        .addr      (bus_addr),
        .we        (bus_we),
        .access_en (ena_q),
        .sel       (sel),
        .wr_mode   (wr_mode),
        .wr_pwr    (wr_pwr),
        .wr_eblk   (wr_eblk),
        .wr_ena    (wr_ena)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ena_q <= 1'b0;
        end else if (wr_ena) begin
            ena_q <= bus_wdata[ENA_BIT];
        end
    end

    fmg_mode_ctl u_mode (
        .clk      (clk),
        .rst      (rst),
        .standby  (standby_i),
        .wr       (wr_mode),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .wen_next (wen_next)
    );

    fmg_dep_reg #(.W(EBLK_W)) u_eblk (
        .clk     (clk),
        .rst     (rst),
        .hold_ok (wen_next),
        .wr      (wr_eblk),
        .wdata   (bus_wdata[EBLK_W-1:0]),
        .q       (eblk_q)
    );

    fmg_dep_reg #(.W(PWR_W)) u_pwr (
        .clk     (clk),
        .rst     (rst),
        .hold_ok (wen_next),
        .wr      (wr_pwr),
        .wdata   (bus_wdata[PWR_W-1:0]),
        .q       (pwr_q)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_MODE: if (ena_q) bus_rdata = mode_q & 8'h7F;
            SEL_PWR:  if (ena_q) bus_rdata = DATA_W'(pwr_q);
            SEL_EBLK: if (ena_q) bus_rdata = DATA_W'(eblk_q);
            SEL_ENA:  bus_rdata[ENA_BIT] = ena_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign mode_prog_o  = mode_q.prg;
    assign mode_pvfy_o  = mode_q.pvfy;
    assign mode_erase_o = mode_q.ers;
    assign mode_evfy_o  = mode_q.evfy;
    assign erase_blk_o  = eblk_q;
    assign pwr_ctl_o    = pwr_q;

endmodule

// File: rtl/fmg_checker.sv
module fmg_checker
    import fmg_pkg::*;
#(
    parameter int unsigned EBLK_W = 5,
    parameter int unsigned PWR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              standby_i,
    input logic              ena_q,
    input sel_e              sel,
    input mode_t             mode_q,
    input logic [7:0]        bus_rdata,
    input logic              mode_prog_o,
    input logic              mode_pvfy_o,
    input logic              mode_erase_o,
    input logic              mode_evfy_o,
    input logic [EBLK_W-1:0] erase_blk_o,
    input logic [PWR_W-1:0]  pwr_ctl_o
);

    p_gate_read_r2: assert property (@(posedge clk) disable iff (rst)
        (!ena_q && (sel == SEL_MODE || sel == SEL_PWR || sel == SEL_EBLK || sel == SEL_STAT))
        |-> (bus_rdata == 8'h00));

    p_rsv_zero_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> !mode_q.rsv);

    p_prog_order_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_prog_o) |-> $past(mode_q.psu));

    p_erase_order_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_erase_o) |-> $past(mode_q.esu));

    p_wen_low_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !mode_q.wen |-> (mode_q[5:0] == 6'd0));

    p_dep_clear_r10: assert property (@(posedge clk) disable iff (rst)
        !mode_q.wen |-> (erase_blk_o == '0 && pwr_ctl_o == '0));

    p_standby_clear_r12: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> (mode_q == '0));

    p_one_mode_r13: assert property (@(posedge clk) disable iff (rst)
        $countones({mode_prog_o, mode_pvfy_o, mode_erase_o, mode_evfy_o}) <= 1);

endmodule

bind flash_mode_guard fmg_checker #(.EBLK_W(EBLK_W), .PWR_W(PWR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .standby_i    (standby_i),
    .ena_q        (ena_q),
    .sel          (sel),
    .mode_q       (mode_q),
    .bus_rdata    (bus_rdata),
    .mode_prog_o  (mode_prog_o),
    .mode_pvfy_o  (mode_pvfy_o),
    .mode_erase_o (mode_erase_o),
    .mode_evfy_o  (mode_evfy_o),
    .erase_blk_o  (erase_blk_o),
    .pwr_ctl_o    (pwr_ctl_o)
);

// File: tb/flash_mode_guard_tb.sv
`timescale 1ns/1ps
module flash_mode_guard_tb;

    localparam logic [15:0] AM = 16'hFF90;
    localparam logic [15:0] AS = 16'hFF91;
    localparam logic [15:0] AP = 16'hFF92;
    localparam logic [15:0] AB = 16'hFF93;
    localparam logic [15:0] AE = 16'hFF9B;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        standby_i = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rdata;
    logic        mode_prog_o, mode_pvfy_o, mode_erase_o, mode_evfy_o;
    logic [4:0]  erase_blk_o;
    logic [7:0]  pwr_ctl_o;

    int checks = 0;
    int errs   = 0;

    logic [7:0] m_mode = 8'h00;
    logic [7:0] m_pwr  = 8'h00;
    logic [4:0] m_eblk = 5'h00;
    logic       m_ena  = 1'b0;

    always #5 clk = ~clk;

    flash_mode_guard u_dut (
        .clk          (clk),
        .rst          (rst),
        .standby_i    (standby_i),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_we       (bus_we),
        .bus_rdata    (bus_rdata),
        .mode_prog_o  (mode_prog_o),
        .mode_pvfy_o  (mode_pvfy_o),
        .mode_erase_o (mode_erase_o),
        .mode_evfy_o  (mode_evfy_o),
        .erase_blk_o  (erase_blk_o),
        .pwr_ctl_o    (pwr_ctl_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones4(input logic [3:0] v);
        return int'(v[0]) + int'(v[1]) + int'(v[2]) + int'(v[3]);
    endfunction

    // Expected mode byte after an accepted write (R3..R9).
    function automatic logic [7:0] exp_mode(input logic [7:0] cur, input logic [7:0] w);
        logic [7:0] c;
        if (!cur[6]) return {1'b0, w[6], 6'd0};
        if (!w[6])   return 8'h00;
        c = {2'b01, w[5:2], w[1] & w[5] & cur[5], w[0] & w[4] & cur[4]};
        if (ones4(c[3:0]) > 1) return cur;
        return c;
    endfunction

    function automatic logic [7:0] exp_read(input logic [15:0] a);
        case (a)
            AM:      return m_ena ? m_mode : 8'h00;
            AP:      return m_ena ? m_pwr : 8'h00;
            AB:      return m_ena ? {3'b000, m_eblk} : 8'h00;
            AE:      return {m_ena, 7'd0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_edge(input logic [15:0] a, input logic [7:0] d, input logic we, input logic sb);
        logic [7:0] nm;
        logic [7:0] np;
        logic [4:0] nb;
        logic       ne;
        ne = (we && a == AE) ? d[7] : m_ena;
        nm = m_mode;
        if (sb) nm = 8'h00;
        else if (we && m_ena && a == AM) nm = exp_mode(m_mode, d);
        np = m_pwr;
        nb = m_eblk;
        if (!nm[6]) begin
            np = 8'h00;
            nb = 5'h00;
        end else begin
            if (we && m_ena && a == AP) np = d;
            if (we && m_ena && a == AB) nb = d[4:0];
        end
        m_mode = nm; m_pwr = np; m_eblk = nb; m_ena = ne;
    endtask

    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic we, input logic sb);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = we; standby_i = sb;
        @(posedge clk);
        model_edge(a, d, we, sb);
        #1;
        chk("R13 mode outputs", {28'd0, mode_evfy_o, mode_erase_o, mode_pvfy_o, mode_prog_o},
            {28'd0, m_mode[3], m_mode[1], m_mode[2], m_mode[0]});
        chk("R10 erase block", {27'd0, erase_blk_o}, {27'd0, m_eblk});
        chk("R11 power ctl", {24'd0, pwr_ctl_o}, {24'd0, m_pwr});
        chk("R2 read data", {24'd0, bus_rdata}, {24'd0, exp_read(a)});
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0; standby_i = 1'b0;
        #1;
        chk(tag, {24'd0, bus_rdata}, {24'd0, exp});
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 outputs after reset", {18'd0, mode_prog_o, mode_pvfy_o, mode_erase_o, mode_evfy_o,
            erase_blk_o, pwr_ctl_o}, 32'd0);
        rd("R1 enable reg reset", AE, 8'h00);

        step(AM, 8'h40, 1'b1, 1'b0);
        step(AE, 8'hFF, 1'b1, 1'b0);
        rd("R2 enable reads bit7 only", AE, 8'h80);
        rd("R2 gated write was ignored", AM, 8'h00);

        step(AS, 8'hFF, 1'b1, 1'b0);
        rd("R14 status reads zero", AS, 8'h00);

        step(AM, 8'hFF, 1'b1, 1'b0);
        rd("R4 only write-enable taken", AM, 8'h40);
        rd("R3 reserved bit reads zero", AM, 8'h40);

        step(AM, 8'h41, 1'b1, 1'b0);
        chk("R5 program without setup", {31'd0, mode_prog_o}, 32'd0);
        step(AM, 8'h50, 1'b1, 1'b0);
        step(AM, 8'h51, 1'b1, 1'b0);
        chk("R5 program after setup", {31'd0, mode_prog_o}, 32'd1);

        step(AM, 8'h11, 1'b1, 1'b0);
        rd("R8 clearing write-enable clears all", AM, 8'h00);

        step(AM, 8'h40, 1'b1, 1'b0);
        step(AE, 8'h00, 1'b1, 1'b0);
        rd("R2 read gated while disabled", AM, 8'h00);
        step(AM, 8'h00, 1'b1, 1'b0);
        step(AE, 8'h80, 1'b1, 1'b0);
        rd("R2 disabled write ignored", AM, 8'h40);

        step(AM, 8'h42, 1'b1, 1'b0);
        chk("R6 erase without setup", {31'd0, mode_erase_o}, 32'd0);
        step(AM, 8'h60, 1'b1, 1'b0);
        step(AM, 8'h62, 1'b1, 1'b0);
        chk("R6 erase after setup", {31'd0, mode_erase_o}, 32'd1);

        step(AM, 8'h7F, 1'b1, 1'b0);
        rd("R9 multi-action rejected", AM, 8'h62);
        step(AM, 8'h4C, 1'b1, 1'b0);
        rd("R9 two verify bits rejected", AM, 8'h62);

        step(AM, 8'h40, 1'b1, 1'b0);
        step(AM, 8'h44, 1'b1, 1'b0);
        chk("R7 program-verify", {31'd0, mode_pvfy_o}, 32'd1);
        step(AM, 8'h48, 1'b1, 1'b0);
        chk("R7 erase-verify", {30'd0, mode_evfy_o, mode_pvfy_o}, 32'd2);

        step(AM, 8'h00, 1'b1, 1'b0);
        step(AB, 8'hFF, 1'b1, 1'b0);
        rd("R10 erase block held at zero", AB, 8'h00);
        step(AM, 8'h40, 1'b1, 1'b0);
        step(AB, 8'hFF, 1'b1, 1'b0);
        rd("R10 erase block upper bits zero", AB, 8'h1F);
        step(AP, 8'hA5, 1'b1, 1'b0);
        rd("R11 power ctl write", AP, 8'hA5);
        step(AM, 8'h00, 1'b1, 1'b0);
        chk("R10 erase block cleared with write-enable", {27'd0, erase_blk_o}, 32'd0);
        chk("R11 power ctl cleared with write-enable", {24'd0, pwr_ctl_o}, 32'd0);

        step(AM, 8'h40, 1'b1, 1'b0);
        step(AM, 8'h50, 1'b1, 1'b0);
        step(AB, 8'h0A, 1'b1, 1'b0);
        step(AM, 8'h51, 1'b1, 1'b1);
        chk("R12 standby beats write", {31'd0, mode_prog_o}, 32'd0);
        rd("R12 mode cleared by standby", AM, 8'h00);
        chk("R12 erase block cleared by standby", {27'd0, erase_blk_o}, 32'd0);

        for (int i = 0; i < 4000; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            logic        we;
            logic        sb;
            case ($urandom_range(0, 7))
                0, 1:    a = AM;
                2:       a = AS;
                3:       a = AP;
                4:       a = AB;
                5:       a = AE;
                6:       a = AM;
                default: a = 16'($urandom);
            endcase
            d  = 8'($urandom);
            if (a == AM && $urandom_range(0, 3) != 0) d[6] = 1'b1;
            if (a == AE && $urandom_range(0, 3) != 0) d[7] = 1'b1;
            we = ($urandom_range(0, 3) != 0);
            sb = ($urandom_range(0, 31) == 0);
            step(a, d, we, sb);
        end

        @(negedge clk);
        bus_we = 1'b0;
        standby_i = 1'b0;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule